// File: doc/BRIEF.md
# Buffered SPI Slave Shifter

This block is a byte-wide SPI target that follows a remote master in any of the four clock polarity and phase combinations. The master starts every transfer. Each byte the master clocks in is matched by a byte clocked out of a transmit buffer, so to read data the master must send a byte. An active-low select line enables the target. While the line is high, the target ignores the serial clock and data, clears its bit counter, and holds its serial output high so that several targets can share one wired-AND return line.

The serial inputs are brought into the system clock through synchronizer flops. Edge detectors then turn the synchronized serial clock into two events, one for sampling and one for shifting. Each received bit is first held in a one-bit staging flop on the sampling edge. It enters the shift register on the opposite edge. A four-address register port lets the host fill the transmit buffer, collect received bytes, and read a control/status byte. One interrupt line follows either the transmit-buffer-empty flag or a sticky transfer-complete flag, chosen by one mode bit.

Top module: `spi_target_shifter`

## Requirements
- R1: After reset the control/status byte (address 2) reads 0x10, meaning transmit buffer empty and all control bits clear. The serial output is 1 and the interrupt output is 0.
- R2: In all four combinations of polarity (control bit 2) and phase (control bit 3), a byte the master shifts in is delivered at address 1. The byte written at address 0 is the byte the master receives.
- R3: Control bit 1 set makes both directions least significant bit first. Clear means most significant bit first.
- R4: With phase 0, asserting select moves the transmit buffer into the shifter. The first output bit is then valid before the first serial clock edge.
- R5: While select is high, the serial output is 1 and serial clock and data edges have no effect. Deselecting in mid-byte drops the partial byte without completing it, and the next selected byte starts again from its first bit.
- R6: Status bit 4 (transmit empty) is cleared by a host write to address 0. It is set when the buffer moves into the shifter.
- R7: Status bit 5 (receive full) is set when a byte completes and is cleared by a host read of address 1.
- R8: Status bit 6 (transfer complete) is set when a byte completes. Only a host read of address 2 clears it; a read of address 1 leaves it set.
- R9: Status bit 7 (overrun) is set when a byte completes while receive full is still set. A read of address 2 clears it.
- R10: Address 3 bit 1 selects the interrupt source. Clear makes the interrupt follow transmit empty, and set makes it follow transfer complete.
- R11: Control bit 0 is the enable. While it is clear the block behaves as if deselected, no buffer moves, and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low target select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 1 when idle |
| cpu_addr | input | 2 | Register address: 0 transmit, 1 receive, 2 control/status, 3 mode |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe; side effects occur at the clock edge |
| cpu_wdata | input | W | Register write data |
| cpu_rdata | output | W | Register read data, combinational from the address |
| irq | output | 1 | Interrupt request level |

## Verification
The bench works through every polarity and phase combination in both bit orders, using asymmetric byte values. A target that ignored the bit order would return the byte reversed, and one that sampled on the wrong edge would return it shifted by one bit. It then drops select after four bits and sends a full byte. A design that kept its bit count would complete that byte early or misaligned, and one that completed the partial byte would raise receive full. Further tests let two bytes complete without a read to force an overrun, and read the receive buffer while the complete interrupt is selected. A design that cleared the sticky flag on the wrong read would drop the interrupt too early. The last test runs a transfer with the enable clear, and any output other than all ones shows the shifter was not held idle.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam logic [1:0] A_TX   = 2'd0;
  localparam logic [1:0] A_RX   = 2'd1;
  localparam logic [1:0] A_CSR  = 2'd2;
  localparam logic [1:0] A_MODE = 2'd3;

  localparam int CSR_EN   = 0;
  localparam int CSR_LSB  = 1;
  localparam int CSR_CPOL = 2;
  localparam int CSR_CPHA = 3;
  localparam int MODE_IRQ = 1;
endpackage

// File: rtl/sts_sync.sv
module sts_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sts_shifter.sv
module sts_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         ssn_s,
  input  logic         mosi_s,
  input  logic         en,
  input  logic         lsb,
  input  logic         cpol,
  input  logic         cpha,
  input  logic [W-1:0] tx_data,
  output logic         miso,
  output logic         active,
  output logic         load_ev,
  output logic         done_ev,
  output logic [W-1:0] done_data,
  output logic [$clog2(W+1)-1:0] bit_cnt
);
  localparam int CW = $clog2(W+1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] r, input logic b,
                                             input logic lsbf);
    return lsbf ? {b, r[W-1:1]} : {r[W-2:0], b};
  endfunction

  function automatic logic out_bit(input logic [W-1:0] r, input logic lsbf);
    return lsbf ? r[0] : r[W-1];
  endfunction

  logic [W-1:0] shreg;
  logic         stage;
  logic         pend;
  logic         sclk_q, act_q;
  logic         rise, fall, lead, trail;
  logic         sample_ev, shift_ev, act_rise;
  logic [W-1:0] shifted;

  assign active    = en & ~ssn_s;
  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign lead      = cpol ? fall : rise;
  assign trail     = cpol ? rise : fall;
  assign sample_ev = active & (cpha ? trail : lead);
  assign shift_ev  = active & (cpha ? lead : trail);
  assign act_rise  = active & ~act_q;
  assign shifted   = shift_in(shreg, stage, lsb);
  assign done_data = shifted;

  assign load_ev = active & ((~cpha & act_rise) |
                   (shift_ev & ~act_rise & ~pend & (cpha ? (bit_cnt == '0) : (bit_cnt == CNT_FULL))));
  assign done_ev = active & (cpha ? pend : (shift_ev & ~act_rise & (bit_cnt == CNT_FULL)));

  assign miso = active ? out_bit(shreg, lsb) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      stage   <= 1'b0;
      pend    <= 1'b0;
      bit_cnt <= '0;
      sclk_q  <= 1'b1;
      act_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      act_q  <= active;
      if (!active) begin
        bit_cnt <= '0;
        pend    <= 1'b0;
        stage   <= 1'b0;
      end else if (act_rise && !cpha) begin
        shreg   <= tx_data;
        bit_cnt <= '0;
      end else if (pend) begin
        shreg   <= shifted;
        bit_cnt <= '0;
        pend    <= 1'b0;
      end else if (sample_ev && bit_cnt != CNT_FULL) begin
        stage   <= mosi_s;
        bit_cnt <= bit_cnt + 1'b1;
        if (cpha && bit_cnt == CNT_LAST) pend <= 1'b1;
      end else if (shift_ev) begin
        if (cpha) begin
          shreg <= (bit_cnt == '0) ? tx_data : shifted;
        end else if (bit_cnt == CNT_FULL) begin
          shreg   <= tx_data;
          bit_cnt <= '0;
        end else if (bit_cnt != '0) begin
          shreg <= shifted;
        end
      end
    end
  end
endmodule

// File: rtl/sts_regs.sv
module sts_regs
  import sts_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cpu_addr,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic         load_ev,
  input  logic         done_ev,
  input  logic [W-1:0] done_data,
  output logic [W-1:0] tx_data,
  output logic         en,
  output logic         lsb,
  output logic         cpol,
  output logic         cpha,
  output logic         irq_sel,
  output logic         tx_empty,
  output logic         rx_full,
  output logic         done_flag,
  output logic         overrun,
  output logic         irq
);
  logic [3:0]   ctrl;
  logic [W-1:0] rx_data;
  logic [7:0]   csr;
  logic         wr_tx, wr_csr, wr_mode, rd_rx, rd_csr;

  assign wr_tx   = cpu_wr & (cpu_addr == A_TX);
  assign wr_csr  = cpu_wr & (cpu_addr == A_CSR);
  assign wr_mode = cpu_wr & (cpu_addr == A_MODE);
  assign rd_rx   = cpu_rd & (cpu_addr == A_RX);
  assign rd_csr  = cpu_rd & (cpu_addr == A_CSR);

  assign en   = ctrl[CSR_EN];
  assign lsb  = ctrl[CSR_LSB];
  assign cpol = ctrl[CSR_CPOL];
  assign cpha = ctrl[CSR_CPHA];
  assign csr  = {overrun, done_flag, rx_full, tx_empty, ctrl};
  assign irq  = en & (irq_sel ? done_flag : tx_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      irq_sel   <= 1'b0;
      tx_data   <= '0;
      rx_data   <= '0;
      tx_empty  <= 1'b1;
      rx_full   <= 1'b0;
      done_flag <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (wr_csr)  ctrl    <= cpu_wdata[3:0];
      if (wr_mode) irq_sel <= cpu_wdata[MODE_IRQ];
      if (wr_tx)   tx_data <= cpu_wdata;
      if (load_ev) tx_empty <= 1'b1;
      if (wr_tx)   tx_empty <= 1'b0;
      if (rd_rx)   rx_full <= 1'b0;
      if (rd_csr) begin
        done_flag <= 1'b0;
        overrun   <= 1'b0;
      end
      if (done_ev) begin
        rx_data   <= done_data;
        rx_full   <= 1'b1;
        done_flag <= 1'b1;
        if (rx_full && !rd_rx) overrun <= 1'b1;
      end
    end
  end

  always_comb begin
    case (cpu_addr)
      A_RX:    cpu_rdata = rx_data;
      A_CSR:   cpu_rdata = W'(csr);
      A_MODE:  cpu_rdata = W'({6'b0, irq_sel, 1'b0});
      default: cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_target_shifter.sv
module spi_target_shifter #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         ss_n,
  input  logic         mosi,
  output logic         miso,
  input  logic [1:0]   cpu_addr,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  output logic         irq
);
  localparam int CW = $clog2(W + 1);

  logic         sclk_s, ssn_s, mosi_s;
  logic         en, lsb, cpol, cpha, irq_sel;
  logic         active, load_ev, done_ev;
  logic [W-1:0] tx_data, done_data;
  logic [CW-1:0] bit_cnt;
  logic         tx_empty, rx_full, done_flag, overrun;

  sts_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, ss_n, mosi}),
    .q({sclk_s, ssn_s, mosi_s})
  );

  sts_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .ssn_s(ssn_s), .mosi_s(mosi_s),
    .en(en), .lsb(lsb), .cpol(cpol), .cpha(cpha),
    .tx_data(tx_data), .miso(miso), .active(active),
    .load_ev(load_ev), .done_ev(done_ev), .done_data(done_data),
    .bit_cnt(bit_cnt)
  );

  sts_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .load_ev(load_ev), .done_ev(done_ev), .done_data(done_data),
    .tx_data(tx_data), .en(en), .lsb(lsb), .cpol(cpol), .cpha(cpha),
    .irq_sel(irq_sel), .tx_empty(tx_empty), .rx_full(rx_full),
    .done_flag(done_flag), .overrun(overrun), .irq(irq)
  );
endmodule

// File: rtl/sts_checker.sv
module sts_checker
  import sts_pkg::*;
#(
  parameter int W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             cpu_addr,
  input logic                   cpu_wr,
  input logic                   cpu_rd,
  input logic                   active,
  input logic                   load_ev,
  input logic                   done_ev,
  input logic [$clog2(W+1)-1:0] bit_cnt,
  input logic                   en,
  input logic                   irq_sel,
  input logic                   tx_empty,
  input logic                   rx_full,
  input logic                   done_flag,
  input logic                   overrun,
  input logic                   irq
);
  localparam int CW = $clog2(W + 1);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(W));

  // R5
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !done_ev);

  // R5
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !load_ev);

  // R6
  txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == A_TX) |=> !tx_empty);

  // R6
  txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !(cpu_wr && cpu_addr == A_TX)) |=> tx_empty);

  // R7
  rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> rx_full);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !(cpu_rd && cpu_addr == A_CSR)) |=> done_flag);

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && rx_full && !(cpu_rd && cpu_addr == A_RX)) |=> overrun);

  // R10
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && irq_sel && done_flag) |-> irq);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);
endmodule

bind spi_target_shifter sts_checker #(.W(W)) u_sts_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .active(active), .load_ev(load_ev), .done_ev(done_ev), .bit_cnt(bit_cnt),
  .en(en), .irq_sel(irq_sel), .tx_empty(tx_empty), .rx_full(rx_full),
  .done_flag(done_flag), .overrun(overrun), .irq(irq)
);

// File: tb/spi_target_shifter_bench.sv
module spi_target_shifter_bench;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       miso, irq;
  int         total = 0, fails = 0;

  always #10 clk = ~clk;

  spi_target_shifter u_spi_target_shifter (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .cpu_addr(addr), .cpu_wr(wr), .cpu_rd(rd), .cpu_wdata(wdata), .cpu_rdata(rdata),
    .irq(irq)
  );

  // {cpol, cpha, lsb_first, byte from master, byte from target}
  localparam logic [18:0] VEC [8] = '{
    {3'b000, 8'h3C, 8'hA7}, {3'b001, 8'h1E, 8'hC5},
    {3'b010, 8'h96, 8'h4B}, {3'b011, 8'h70, 8'h2D},
    {3'b100, 8'hE1, 8'h58}, {3'b101, 8'h0F, 8'hB3},
    {3'b110, 8'h6A, 8'h91}, {3'b111, 8'hD4, 8'h37}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic xfer(input logic cpol, input logic cpha, input logic lsbf,
                      input logic [7:0] mo, input int nbits, output logic [7:0] got);
    got = 8'hFF;
    sclk = cpol;
    wait_h();
    ss_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = lsbf ? i : 7 - i;
      if (!cpha) begin
        mosi = mo[idx];
        wait_h();
        got[idx] = miso;
        sclk = ~cpol;
        wait_h();
        sclk = cpol;
      end else begin
        wait_h();
        sclk = ~cpol;
        mosi = mo[idx];
        wait_h();
        got[idx] = miso;
        sclk = cpol;
      end
    end
    wait_h(); wait_h();
    ss_n = 1'b1;
    wait_h();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] r, got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cpu_read(2'd2, r); check("R1 csr", r, 8'h10);
    check("R1 miso", {7'b0, miso}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2/R3 vector table over all modes and both orders
    for (int v = 0; v < 8; v++) begin
      logic [7:0] ctl;
      ctl = {4'b0, VEC[v][17], VEC[v][18], VEC[v][16], 1'b1};
      sclk = VEC[v][18];
      cpu_write(2'd2, ctl);
      cpu_write(2'd0, VEC[v][7:0]);
      xfer(VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:8], 8, got);
      check("R2/R3 master got tx byte", got, VEC[v][7:0]);
      cpu_read(2'd2, r); check("R6/R7/R8 csr after byte", r, 8'h70 | ctl);
      cpu_read(2'd1, r); check("R2/R3/R7 rx byte", r, VEC[v][15:8]);
    end

    // R4 phase-0 preload on select, msb first then lsb first
    sclk = 1'b0;
    cpu_write(2'd2, 8'h01);
    cpu_write(2'd0, 8'h5A);
    cpu_read(2'd2, r); check("R6 write clears empty", r, 8'h01);
    wait_h(); ss_n = 1'b0; wait_h();
    check("R4 first bit msb", {7'b0, miso}, 8'h00);
    cpu_read(2'd2, r); check("R6 load sets empty", r, 8'h11);
    ss_n = 1'b1; wait_h();
    check("R5 idle miso", {7'b0, miso}, 8'h01);
    cpu_write(2'd2, 8'h03);
    cpu_write(2'd0, 8'hA4);
    ss_n = 1'b0; wait_h();
    check("R3/R4 first bit lsb", {7'b0, miso}, 8'h00);
    ss_n = 1'b1; wait_h();

    // R5 mid-byte deselect and ignored clocks
    cpu_write(2'd2, 8'h01);
    cpu_write(2'd0, 8'hFF);
    xfer(1'b0, 1'b0, 1'b0, 8'h00, 4, got);
    cpu_read(2'd2, r); check("R5 partial byte dropped", r, 8'h11);
    for (int k = 0; k < 8; k++) begin
      mosi = k[0]; sclk = 1'b1; wait_h(); sclk = 1'b0; wait_h();
    end
    check("R5 miso high deselected", {7'b0, miso}, 8'h01);
    cpu_read(2'd2, r); check("R5 clocks ignored", r, 8'h11);
    cpu_write(2'd0, 8'h3E);
    xfer(1'b0, 1'b0, 1'b0, 8'hC3, 8, got);
    check("R5 restart tx", got, 8'h3E);
    cpu_read(2'd2, r); check("R5 restart csr", r, 8'h71);
    cpu_read(2'd1, r); check("R5 restart rx", r, 8'hC3);

    // R8/R9/R10 sticky complete, overrun, interrupt select
    cpu_write(2'd3, 8'h02);
    xfer(1'b0, 1'b0, 1'b0, 8'h11, 8, got);
    check("R10 irq on complete", {7'b0, irq}, 8'h01);
    cpu_read(2'd1, r); check("R7 rx read", r, 8'h11);
    check("R8 rx read keeps irq", {7'b0, irq}, 8'h01);
    xfer(1'b0, 1'b0, 1'b0, 8'h22, 8, got);
    xfer(1'b0, 1'b0, 1'b0, 8'h33, 8, got);
    cpu_read(2'd2, r); check("R9 overrun csr", r, 8'hF1);
    check("R8 csr read clears irq", {7'b0, irq}, 8'h00);
    cpu_read(2'd1, r); check("R9 newest byte kept", r, 8'h33);
    cpu_read(2'd2, r); check("R9 cleared", r, 8'h11);
    cpu_write(2'd3, 8'h00);
    check("R10 irq on empty", {7'b0, irq}, 8'h01);
    cpu_write(2'd0, 8'h77);
    check("R10/R6 irq drops on write", {7'b0, irq}, 8'h00);

    // R11 disabled block stays idle
    cpu_write(2'd2, 8'h00);
    xfer(1'b0, 1'b0, 1'b0, 8'h99, 8, got);
    check("R11 miso idle", got, 8'hFF);
    cpu_read(2'd2, r); check("R11 no load or completion", r, 8'h00);
    check("R11 irq gated", {7'b0, irq}, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule